// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one complete operation on a raw 8-bit asynchronous NAND flash bus each time it is started. The request fields are sampled when the block is started. They give a leading command byte, an optional trailing command byte, a number of address bytes and the address bytes themselves, an optional short receive burst, and a chip-enable select. From these the block produces the whole pin-level sequence. It asserts chip enable and waits a setup time. It then sends the command cycle with the command latch, the address cycles with the address latch and the trailing command. After a recovery time it waits for the device to report ready, and then reads up to four bytes with read-enable strobes.

Received bytes are packed little-endian into one response word. Two sticky flags report the result: one marks normal completion and the other marks a ready/busy wait that ran past a programmable limit. A software-style driver can therefore issue reset, identify, status, erase, page-read setup and page-program setup sequences with a single launch. All phase durations are static count inputs given in clock cycles.

Top module: `nand_seq`

## Requirements
- R1: After reset, busy, done and timeout are low, the response word is zero, chip enable, write enable and read enable are high (inactive), both latch enables are low and the data bus is not driven.
- R2: A one-cycle pulse on go while idle starts a sequence, and busy stays high until that sequence ends. A go pulse that arrives while busy is high is ignored: no extra bus cycle is produced and the latched command is not changed.
- R3: Bus cycles come in a fixed order. First is the leading command with the command latch high. Next come the address bytes with the address latch high, starting from addr_i[7:0] and moving up one byte at a time, so that the column bytes come before the row bytes. Last, when cmd2_en_i is set, the trailing command is sent with the command latch high. An address count above the parameter MAX_ADDR (default 5) is treated as MAX_ADDR.
- R4: The command latch and address latch are never high together. On every write cycle, write enable is low for max(t_wp_i,1) cycles and then high for max(t_wh_i,1) cycles before the next write cycle.
- R5: Chip enable falls exactly t_cs_m1_i+1 cycles before the first falling edge of write enable (the setup count is programmed as the required count minus one).
- R6: After the last write cycle finishes its high phase, the block waits t_rr_m2_i+2 cycles before it samples ready/busy. The setup count is programmed as the required count minus two. With the device ready, the first read-enable falling edge therefore comes t_wh+t_rr_m2_i+3 cycles after the last write-enable rise.
- R7: No read strobe is issued and done is not set while ready/busy (1 = ready) is low. Done is set only after ready has been seen.
- R8: If ready/busy stays low for busy_limit_i+1 cycles of the wait, the sequence ends with timeout set, done not set and no read strobes issued.
- R9: When rx_en_i is set, rx_len_i+1 bytes are read (the length field is the count minus one). Read enable is low for max(t_rp_i,1) cycles and high for max(t_rh_i,1) cycles between reads. Byte n goes to resp_o[8n+7:8n], the unused upper bytes read as zero, and the response word is cleared at each launch.
- R10: Writing one to clr_done_i clears done and writing one to clr_tmo_i clears timeout. Each flag otherwise holds its value once set.
- R11: With ce_sel_i low, the sequence still runs on the latch, strobe and data pins, but chip enable stays high the whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Launch pulse |
| cmd1_i | input | 8 | Leading command byte |
| cmd2_i | input | 8 | Trailing command byte |
| cmd2_en_i | input | 1 | Send the trailing command |
| addr_cnt_i | input | 3 | Number of address bytes |
| addr_i | input | 40 | Address bytes, lowest byte sent first |
| rx_en_i | input | 1 | Read a burst after ready |
| rx_len_i | input | 2 | Burst length minus one |
| ce_sel_i | input | 1 | Assert chip enable 0 |
| t_wp_i | input | 8 | Write-enable low cycles |
| t_wh_i | input | 8 | Write-enable high cycles |
| t_rp_i | input | 8 | Read-enable low cycles |
| t_rh_i | input | 8 | Read-enable high cycles |
| t_cs_m1_i | input | 8 | Chip-enable setup cycles minus one |
| t_rr_m2_i | input | 8 | Recovery cycles minus two |
| busy_limit_i | input | 16 | Ready/busy wait limit |
| clr_done_i | input | 1 | Write-one-to-clear for done |
| clr_tmo_i | input | 1 | Write-one-to-clear for timeout |
| busy_o | output | 1 | Sequence active (go bit) |
| done_o | output | 1 | Sticky completion flag |
| tmo_o | output | 1 | Sticky timeout flag |
| resp_o | output | 32 | Packed received bytes |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_o | output | 8 | Data bus out |
| nand_io_oe | output | 1 | Data bus drive enable |
| nand_io_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Ready/busy, 1 = ready |

## Verification
The bench checks the boundaries of the pulse counts. A zero low count must still give a one-cycle strobe, and the setup and recovery offsets of one and two must appear exactly, so a design that drops an offset shifts the measured edge distance by a cycle. An address count of seven must be clamped to five bytes; without the clamp the bus shows extra address cycles or a wrapped byte. A busy device is held off past the release point to show that no read strobe and no done flag appear early. A device that never becomes ready must end the sequence in timeout rather than hang the block. A go pulse in mid-sequence must produce no extra command cycle. The bench also covers single-byte and four-byte bursts: it checks byte lane order and that stale response bytes are cleared, which catches a reversed packer or a response word that is not cleared at launch.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CLO,
      ST_CHI,
      ST_ALO,
      ST_AHI,
      ST_C2LO,
      ST_C2HI,
      ST_RECOV,
      ST_WAITRB,
      ST_RLO,
      ST_RHI
   } seq_st_e;

endpackage

// File: rtl/nand_seq_tmr.sv
module nand_seq_tmr #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q > W'(1))
         cnt_q <= cnt_q - W'(1);
   end

   assign expired_o = (cnt_q <= W'(1));
endmodule

// File: rtl/nand_seq_pack.sv
module nand_seq_pack #(
   parameter int LANES = 4,
   localparam int IW = $clog2(LANES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  cap_i,
   input  logic [IW-1:0]         idx_i,
   input  logic [7:0]            din_i,
   output logic [8*LANES-1:0]    word_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (clr_i)
            lane_q <= '0;
         else if (cap_i && (idx_i == IW'(g)))
            lane_q <= din_i;
      end
      assign word_o[8*g +: 8] = lane_q;
   end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nand_seq_pkg::*;
#(
   parameter int MAX_ADDR = 5,
   parameter int MAX_RX   = 4,
   parameter int TW       = 8,
   parameter int BW       = 16,
   localparam int ACW  = $clog2(MAX_ADDR + 1),
   localparam int RXIW = $clog2(MAX_RX),
   localparam int AW   = BYTE_W * MAX_ADDR,
   localparam int RW   = BYTE_W * MAX_RX
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [7:0]      cmd1_i,
   input  logic [7:0]      cmd2_i,
   input  logic            cmd2_en_i,
   input  logic [ACW-1:0]  addr_cnt_i,
   input  logic [AW-1:0]   addr_i,
   input  logic            rx_en_i,
   input  logic [RXIW-1:0] rx_len_i,
   input  logic            ce_sel_i,
   input  logic [TW-1:0]   t_wp_i,
   input  logic [TW-1:0]   t_wh_i,
   input  logic [TW-1:0]   t_rp_i,
   input  logic [TW-1:0]   t_rh_i,
   input  logic [TW-1:0]   t_cs_m1_i,
   input  logic [TW-1:0]   t_rr_m2_i,
   input  logic [BW-1:0]   busy_limit_i,
   input  logic            clr_done_i,
   input  logic            clr_tmo_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            tmo_o,
   output logic [RW-1:0]   resp_o,
   output logic            nand_ce_n,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [7:0]      nand_io_o,
   output logic            nand_io_oe,
   input  logic [7:0]      nand_io_i,
   input  logic            nand_rb_i
);
   localparam int TMW = TW + 2;

   initial begin
      if (MAX_ADDR < 1 || MAX_ADDR > 8)
         $error("nand_seq: MAX_ADDR out of range 1..8");
      if (MAX_RX < 2 || (MAX_RX & (MAX_RX - 1)) != 0)
         $error("nand_seq: MAX_RX must be a power of two of at least 2");
      if (TW < 2 || BW < 2)
         $error("nand_seq: counter widths too small");
   end

   function automatic logic [TMW-1:0] ext(input logic [TW-1:0] v);
      return {{(TMW-TW){1'b0}}, v};
   endfunction

   seq_st_e st_q, st_d;

   logic [7:0]      cmd1_q, cmd2_q;
   logic            c2en_q, rxen_q, ce_q;
   logic [ACW-1:0]  acnt_q, aidx_q, acnt_eff;
   logic [AW-1:0]   addr_q;
   logic [RXIW-1:0] rxlen_q, ridx_q;
   logic [BW-1:0]   bcnt_q;
   logic            done_q, tmo_q;

   logic            ld, tmr_exp, fin_ok, fin_to, cap, a_inc, r_inc, launch;
   logic [TMW-1:0]  lval;
   seq_st_e         post_wr_st;
   logic [TMW-1:0]  post_wr_val;

   // address count clamp, only built when the count field can exceed MAX_ADDR
   if ((1 << ACW) - 1 > MAX_ADDR) begin : g_clamp
      assign acnt_eff = (addr_cnt_i > ACW'(MAX_ADDR)) ? ACW'(MAX_ADDR) : addr_cnt_i;
   end else begin : g_noclamp
      assign acnt_eff = addr_cnt_i;
   end

   assign launch = (st_q == ST_IDLE) && go_i;

   // where to go after the address phase (or after the leading command when no address)
   always_comb begin
      if (c2en_q) begin
         post_wr_st  = ST_C2LO;
         post_wr_val = ext(t_wp_i);
      end else begin
         post_wr_st  = ST_RECOV;
         post_wr_val = ext(t_rr_m2_i) + TMW'(2);
      end
   end

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      lval   = '0;
      fin_ok = 1'b0;
      fin_to = 1'b0;
      cap    = 1'b0;
      a_inc  = 1'b0;
      r_inc  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (go_i) begin
            st_d = ST_SETUP; ld = 1'b1; lval = ext(t_cs_m1_i) + TMW'(1);
         end
         ST_SETUP: if (tmr_exp) begin
            st_d = ST_CLO; ld = 1'b1; lval = ext(t_wp_i);
         end
         ST_CLO: if (tmr_exp) begin
            st_d = ST_CHI; ld = 1'b1; lval = ext(t_wh_i);
         end
         ST_CHI: if (tmr_exp) begin
            ld = 1'b1;
            if (acnt_q != '0) begin
               st_d = ST_ALO; lval = ext(t_wp_i);
            end else begin
               st_d = post_wr_st; lval = post_wr_val;
            end
         end
         ST_ALO: if (tmr_exp) begin
            st_d = ST_AHI; ld = 1'b1; lval = ext(t_wh_i);
         end
         ST_AHI: if (tmr_exp) begin
            ld = 1'b1;
            if (ACW'(aidx_q + 1'b1) < acnt_q) begin
               st_d = ST_ALO; lval = ext(t_wp_i); a_inc = 1'b1;
            end else begin
               st_d = post_wr_st; lval = post_wr_val;
            end
         end
         ST_C2LO: if (tmr_exp) begin
            st_d = ST_C2HI; ld = 1'b1; lval = ext(t_wh_i);
         end
         ST_C2HI: if (tmr_exp) begin
            st_d = ST_RECOV; ld = 1'b1; lval = ext(t_rr_m2_i) + TMW'(2);
         end
         ST_RECOV: if (tmr_exp) st_d = ST_WAITRB;
         ST_WAITRB: begin
            if (nand_rb_i) begin
               if (rxen_q) begin
                  st_d = ST_RLO; ld = 1'b1; lval = ext(t_rp_i);
               end else begin
                  st_d = ST_IDLE; fin_ok = 1'b1;
               end
            end else if (bcnt_q == busy_limit_i) begin
               st_d = ST_IDLE; fin_to = 1'b1;
            end
         end
         ST_RLO: if (tmr_exp) begin
            st_d = ST_RHI; ld = 1'b1; lval = ext(t_rh_i); cap = 1'b1;
         end
         ST_RHI: if (tmr_exp) begin
            if (ridx_q == rxlen_q) begin
               st_d = ST_IDLE; fin_ok = 1'b1;
            end else begin
               st_d = ST_RLO; ld = 1'b1; lval = ext(t_rp_i); r_inc = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cmd1_q  <= '0;
         cmd2_q  <= '0;
         c2en_q  <= 1'b0;
         rxen_q  <= 1'b0;
         ce_q    <= 1'b0;
         acnt_q  <= '0;
         addr_q  <= '0;
         rxlen_q <= '0;
         aidx_q  <= '0;
         ridx_q  <= '0;
         bcnt_q  <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (launch) begin
            cmd1_q  <= cmd1_i;
            cmd2_q  <= cmd2_i;
            c2en_q  <= cmd2_en_i;
            rxen_q  <= rx_en_i;
            ce_q    <= ce_sel_i;
            acnt_q  <= acnt_eff;
            addr_q  <= addr_i;
            rxlen_q <= rx_len_i;
            aidx_q  <= '0;
            ridx_q  <= '0;
         end else begin
            if (a_inc) aidx_q <= aidx_q + 1'b1;
            if (r_inc) ridx_q <= ridx_q + 1'b1;
         end
         if (st_q == ST_WAITRB)
            bcnt_q <= bcnt_q + 1'b1;
         else
            bcnt_q <= '0;
         if (fin_ok)          done_q <= 1'b1;
         else if (clr_done_i) done_q <= 1'b0;
         if (fin_to)          tmo_q  <= 1'b1;
         else if (clr_tmo_i)  tmo_q  <= 1'b0;
      end
   end

   nand_seq_tmr #(.W(TMW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ld),
      .val_i     (lval),
      .expired_o (tmr_exp)
   );

   nand_seq_pack #(.LANES(MAX_RX)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (launch),
      .cap_i  (cap),
      .idx_i  (ridx_q),
      .din_i  (nand_io_i),
      .word_o (resp_o)
   );

   // pin decode from the registered phase state
   logic in_cmd1, in_addr, in_cmd2;
   assign in_cmd1 = (st_q == ST_CLO)  || (st_q == ST_CHI);
   assign in_addr = (st_q == ST_ALO)  || (st_q == ST_AHI);
   assign in_cmd2 = (st_q == ST_C2LO) || (st_q == ST_C2HI);

   always_comb begin
      if (in_cmd1)      nand_io_o = cmd1_q;
      else if (in_addr) nand_io_o = addr_q[{aidx_q, 3'b000} +: 8];
      else if (in_cmd2) nand_io_o = cmd2_q;
      else              nand_io_o = '0;
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign tmo_o      = tmo_q;
   assign nand_ce_n  = !(busy_o && ce_q);
   assign nand_cle   = in_cmd1 || in_cmd2;
   assign nand_ale   = in_addr;
   assign nand_we_n  = !((st_q == ST_CLO) || (st_q == ST_ALO) || (st_q == ST_C2LO));
   assign nand_re_n  = !(st_q == ST_RLO);
   assign nand_io_oe = in_cmd1 || in_addr || in_cmd2;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic tmo,
   input logic ce_n,
   input logic cle,
   input logic ale,
   input logic we_n,
   input logic re_n,
   input logic oe,
   input logic rb
);
   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (we_n && re_n && ce_n && !oe && !cle && !ale)); // R1
   AST_RE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> (!oe && we_n && !cle && !ale)); // R9
   AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rb)); // R7
   AST_TMO_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo) |-> !$rose(done)); // R8
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy)); // R2
endmodule

bind nand_seq nand_seq_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy_o),
   .done  (done_o),
   .tmo   (tmo_o),
   .ce_n  (nand_ce_n),
   .cle   (nand_cle),
   .ale   (nand_ale),
   .we_n  (nand_we_n),
   .re_n  (nand_re_n),
   .oe    (nand_io_oe),
   .rb    (nand_rb_i)
);

// File: tb/nand_seq_bench.sv
`timescale 1ns/1ps
module nand_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        go = 0, c2en = 0, rxen = 0, cesel = 1, clr_done = 0, clr_tmo = 0, rb = 1;
   logic [7:0]  cmd1 = 0, cmd2 = 0;
   logic [2:0]  acnt = 0;
   logic [39:0] addr = 0;
   logic [1:0]  rxlen = 0;
   logic [7:0]  t_wp = 2, t_wh = 1, t_rp = 3, t_rh = 2, t_cs = 1, t_rr = 1;
   logic [15:0] blim = 40;
   logic        busy, done, tmo, ce_n, cle, ale, we_n, re_n, oe;
   logic [31:0] resp;
   logic [7:0]  io_o, io_i;

   nand_seq u_nand_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go), .cmd1_i(cmd1), .cmd2_i(cmd2),
      .cmd2_en_i(c2en), .addr_cnt_i(acnt), .addr_i(addr), .rx_en_i(rxen),
      .rx_len_i(rxlen), .ce_sel_i(cesel), .t_wp_i(t_wp), .t_wh_i(t_wh),
      .t_rp_i(t_rp), .t_rh_i(t_rh), .t_cs_m1_i(t_cs), .t_rr_m2_i(t_rr),
      .busy_limit_i(blim), .clr_done_i(clr_done), .clr_tmo_i(clr_tmo),
      .busy_o(busy), .done_o(done), .tmo_o(tmo), .resp_o(resp),
      .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
      .nand_re_n(re_n), .nand_io_o(io_o), .nand_io_oe(oe), .nand_io_i(io_i),
      .nand_rb_i(rb)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;

   // bus monitor state, sampled on falling clock edges
   logic [7:0] ndata [4];
   logic [7:0] log_byte [16];
   int log_kind [16], log_wlo [16], log_whi [16], log_rlo [8], log_rhi [8];
   int n_log, n_re, wlo, whi, rlo, rhi, since, re_gap, ce_lead;
   bit both_seen, ce_seen, we_started, prev_we, prev_re;
   logic [7:0] cur_b;
   int cur_k;

   assign io_i = (n_re < 4) ? ndata[n_re] : 8'h00;

   task automatic mon_clear();
      n_log = 0; n_re = 0; wlo = 0; whi = 0; rlo = 0; rhi = 0; since = 0;
      re_gap = -1; ce_lead = 0; both_seen = 0; ce_seen = 0; we_started = 0;
      prev_we = 1; prev_re = 1; cur_b = 0; cur_k = 0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cle && ale) both_seen = 1;
      if (!ce_n) ce_seen = 1;
      if (busy && we_n && !we_started) ce_lead++;
      if (!we_n) begin
         if (prev_we) begin
            we_started = 1;
            if (n_log > 0 && n_log < 16) log_whi[n_log] = whi;
         end
         wlo++; cur_b = io_o; cur_k = cle ? 1 : (ale ? 2 : 0);
      end else if (!prev_we) begin
         if (n_log < 16) begin
            log_byte[n_log] = cur_b; log_kind[n_log] = cur_k; log_wlo[n_log] = wlo;
         end
         n_log++; wlo = 0; whi = 1; since = 0;
      end else begin
         whi++; since++;
      end
      if (!re_n) begin
         if (prev_re) begin
            if (n_re == 0) re_gap = since;
            else if (n_re < 8) log_rhi[n_re] = rhi;
         end
         rlo++;
      end else if (!prev_re) begin
         if (n_re < 8) log_rlo[n_re] = rlo;
         n_re++; rlo = 0; rhi = 1;
      end else rhi++;
      prev_we = we_n; prev_re = re_n;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_byte(input int i, input int kind, input logic [7:0] b, input string req);
      chk(log_kind[i] == kind, req, log_kind[i], kind);
      chk(log_byte[i] == b, req, log_byte[i], b);
   endtask

   task automatic run(input logic [7:0] c1, input logic [7:0] c2, input bit e2,
                      input logic [2:0] ac, input logic [39:0] ad, input bit re,
                      input logic [1:0] rl, input bit cs);
      int guard;
      @(posedge clk); #1; mon_clear();
      @(negedge clk);
      clr_done = 1; clr_tmo = 1;
      @(negedge clk);
      clr_done = 0; clr_tmo = 0;
      cmd1 = c1; cmd2 = c2; c2en = e2; acnt = ac; addr = ad; rxen = re; rxlen = rl;
      cesel = cs; go = 1;
      @(negedge clk);
      go = 0;
      guard = 0;
      while (busy && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic t_reset();
      chk(busy == 0 && done == 0 && tmo == 0, "R1 flags", {busy, done, tmo}, 0);
      chk(resp == 0, "R1 resp", resp, 0);
      chk({ce_n, we_n, re_n, cle, ale, oe} == 6'b111000, "R1 pins",
          {ce_n, we_n, re_n, cle, ale, oe}, 6'b111000);
   endtask

   task automatic t_read_id();
      ndata[0] = 8'h2C; ndata[1] = 8'hDA; ndata[2] = 8'h90; ndata[3] = 8'h95;
      run(8'h90, 8'h00, 0, 3'd1, 40'h00, 1, 2'd3, 1);
      chk(n_log == 2, "R3 id cycles", n_log, 2);
      chk_byte(0, 1, 8'h90, "R3 id cmd");
      chk_byte(1, 2, 8'h00, "R3 id addr");
      chk(n_re == 4, "R9 id count", n_re, 4);
      chk(resp == 32'h9590DA2C, "R9 id packing", resp, 32'h9590DA2C);
      chk(done == 1 && tmo == 0, "R2 id done", {done, tmo}, 2'b10);
      chk(log_rlo[0] == 3 && log_rhi[1] == 2, "R9 re widths", {log_rlo[0], log_rhi[1]}, {32'd3, 32'd2});
      chk(ce_lead == 2, "R5 setup", ce_lead, 2);
      chk(log_wlo[0] == 2 && log_whi[1] == 1, "R4 we widths", {log_wlo[0], log_whi[1]}, {32'd2, 32'd1});
   endtask

   task automatic t_status_short_pulse();
      t_wp = 0;
      ndata[0] = 8'hE0;
      run(8'h70, 8'h00, 0, 3'd0, 40'h0, 1, 2'd0, 1);
      chk(n_log == 1, "R3 status cycles", n_log, 1);
      chk_byte(0, 1, 8'h70, "R3 status cmd");
      chk(log_wlo[0] == 1, "R4 zero count pulse", log_wlo[0], 1);
      chk(resp == 32'h000000E0, "R9 single byte clears old lanes", resp, 32'hE0);
      t_wp = 2;
   endtask

   task automatic t_reset_cmd();
      run(8'hFF, 8'h00, 0, 3'd0, 40'h0, 0, 2'd0, 1);
      chk(n_log == 1 && n_re == 0, "R3 reset only cmd", {n_log, n_re}, {32'd1, 32'd0});
      chk(done == 1, "R2 reset done", done, 1);
   endtask

   task automatic t_erase_busy();
      bit busy_at_rel;
      rb = 0;
      fork
         begin
            repeat (30) @(negedge clk);
            busy_at_rel = busy;
            chk(n_re == 0 && done == 0, "R7 nothing before ready", {n_re, done}, 0);
            rb = 1;
         end
      join_none
      run(8'h60, 8'hD0, 1, 3'd3, 40'h00_00_03_02_01, 0, 2'd0, 1);
      chk(busy_at_rel == 1, "R7 waits on busy", busy_at_rel, 1);
      chk(n_log == 5, "R3 erase cycles", n_log, 5);
      chk_byte(0, 1, 8'h60, "R3 erase cmd1");
      chk_byte(1, 2, 8'h01, "R3 erase a0");
      chk_byte(3, 2, 8'h03, "R3 erase a2");
      chk_byte(4, 1, 8'hD0, "R3 erase cmd2");
      chk(done == 1 && tmo == 0, "R7 erase done", {done, tmo}, 2'b10);
      chk(both_seen == 0, "R4 latch exclusive", both_seen, 0);
   endtask

   task automatic t_page_read();
      ndata[0] = 8'h11; ndata[1] = 8'h22;
      run(8'h00, 8'h30, 1, 3'd5, 40'h55_44_33_22_11, 1, 2'd1, 1);
      chk(n_log == 7, "R3 read cycles", n_log, 7);
      chk_byte(1, 2, 8'h11, "R3 column first");
      chk_byte(5, 2, 8'h55, "R3 row last");
      chk_byte(6, 1, 8'h30, "R3 read cmd2");
      chk(re_gap == 5, "R6 recovery", re_gap, 5);
      chk(resp == 32'h00002211, "R9 two bytes", resp, 32'h2211);
   endtask

   task automatic t_clamp();
      run(8'h80, 8'h10, 0, 3'd7, 40'hAA_BB_CC_DD_EE, 0, 2'd0, 1);
      chk(n_log == 6, "R3 clamp count", n_log, 6);
      chk_byte(5, 2, 8'hAA, "R3 clamp last byte");
   endtask

   task automatic t_timeout();
      blim = 20; rb = 0;
      run(8'h60, 8'hD0, 1, 3'd3, 40'h0, 1, 2'd3, 1);
      chk(busy == 0, "R8 ends", busy, 0);
      chk(tmo == 1 && done == 0, "R8 flags", {tmo, done}, 2'b10);
      chk(n_re == 0, "R8 no reads", n_re, 0);
      repeat (3) @(negedge clk);
      chk(tmo == 1, "R10 tmo holds", tmo, 1);
      clr_tmo = 1; @(negedge clk); clr_tmo = 0;
      chk(tmo == 0, "R10 tmo cleared", tmo, 0);
      rb = 1; blim = 40;
   endtask

   task automatic t_go_ignored();
      fork
         begin
            repeat (4) @(negedge clk);
            cmd1 = 8'hAA; go = 1;
            @(negedge clk);
            go = 0;
         end
      join_none
      ndata[0] = 8'h40;
      run(8'h70, 8'h00, 0, 3'd0, 40'h0, 1, 2'd0, 1);
      repeat (10) @(negedge clk);
      chk(busy == 0 && n_log == 1, "R2 go ignored", {busy, n_log}, 1);
      chk_byte(0, 1, 8'h70, "R2 command kept");
      chk(done == 1, "R10 done holds", done, 1);
      clr_done = 1; @(negedge clk); clr_done = 0;
      chk(done == 0, "R10 done cleared", done, 0);
   endtask

   task automatic t_no_ce();
      run(8'hFF, 8'h00, 0, 3'd0, 40'h0, 0, 2'd0, 0);
      chk(ce_seen == 0, "R11 ce held high", ce_seen, 0);
      chk(n_log == 1 && done == 1, "R11 sequence still runs", {n_log, done}, {32'd1, 1'b1});
   endtask

   initial begin
      fork
         begin
            mon_clear();
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1;
            @(negedge clk);
            t_read_id();
            t_status_short_pulse();
            t_reset_cmd();
            t_erase_busy();
            t_page_read();
            t_clamp();
            t_timeout();
            t_go_ignored();
            t_no_ce();
         end
         begin
            wait (cyc > 150000);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule